// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register core of an eight-pin general-purpose I/O expander. A synchronous parallel bus reaches it through an address, write data, a write strobe, a read strobe and registered read data. On the pin side it samples the pin levels and drives a per-pin output enable and output value. A serial bus front end and the pad circuitry are outside the block.

Three addresses are implemented: a live view of the pin levels, an output latch, and a direction mask. The output latch reads back what was written to it, not what the pin shows. The level view always shows every pin, including pins that are being driven. Pin levels pass through a two-flop synchronizer. After that they feed the read path and a small interrupt state machine. The machine has two states, `IRQ_IDLE` and `IRQ_PEND`. It moves from `IRQ_IDLE` to `IRQ_PEND` when an input-configured pin differs from a snapshot. It moves from `IRQ_PEND` back to `IRQ_IDLE` when the level view is read, and that read also reloads the snapshot. While pending, the active-low interrupt output is low.

Top module: `gpio_regbank`

## Requirements
- R1: After reset, `pin_oe` is 0x00, `pin_out` is 0xFF, `irq_n` is 1 and `rd_data` is 0x00. The output latch, the direction mask, the synchronizer and the snapshot all reset to 0xFF.
- R2: A read with `rd_en`=1 at address 0 returns the synchronized pin levels on `rd_data` one cycle later. This holds for pins configured as outputs as well. A pin change becomes visible after two clock edges.
- R3: A write to address 1 loads the output latch, and `pin_out` equals the latch on the next cycle. A read of address 1 returns the latch contents, whatever the pin levels are.
- R4: A write to address 3 loads the direction mask. A mask bit of 1 makes the pin an input (`pin_oe` bit = 0). A mask bit of 0 makes it an output (`pin_oe` bit = 1). A read of address 3 returns the mask.
- R5: Writes to address 0 or address 2 change no state: the latch, the mask, `pin_out` and `pin_oe` stay as they were.
- R6: A read of address 2 returns 0x00.
- R7: The `IRQ_IDLE` to `IRQ_PEND` transition happens when any synchronized pin whose mask bit is 1 differs from the snapshot. `irq_n` goes low on the edge after the difference appears, which is the third edge after the pin changes.
- R8: A read of address 0 takes `IRQ_PEND` to `IRQ_IDLE`, so `irq_n` is 1 on the next cycle. The same read reloads the snapshot with the synchronized levels.
- R9: A pin whose mask bit is 0 never causes the `IRQ_IDLE` to `IRQ_PEND` transition.
- R10: `rd_data` holds its last value in every cycle without a read strobe. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Pin levels (asynchronous) |
| pin_oe | output | WIDTH | Per-pin output enable, 1 = drive |
| pin_out | output | WIDTH | Per-pin output value |
| irq_n | output | 1 | Active-low change interrupt |

## Verification
The assertions assume that the bus strobes, address and write data are synchronous to `clk` and held stable around each rising edge. Only `pin_in` may change freely, and it is watched only through the synchronizer. The bench changes every input at the falling edge, so the bus inputs never move near a sampling edge. Pin changes are applied at random as well as in directed steps. The bus side is also driven with random combinations of simultaneous read and write, including the unimplemented address.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
    localparam int unsigned ADDR_LEVEL = 0;
    localparam int unsigned ADDR_LATCH = 1;
    localparam int unsigned ADDR_DIR   = 3;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_t;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_regbank_pkg::*;
#(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [WIDTH-1:0]  pin_level,
    output logic [WIDTH-1:0]  rd_data,
    output logic [WIDTH-1:0]  out_latch,
    output logic [WIDTH-1:0]  dir_mask
);
    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(ADDR_LEVEL);
    localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(ADDR_LATCH);
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(ADDR_DIR);

    logic [WIDTH-1:0] rd_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_latch <= '1;
            dir_mask  <= '1;
        end else if (wr_en) begin
            if (addr == A_LATCH) out_latch <= wr_data;
            if (addr == A_DIR)   dir_mask  <= wr_data;
        end
    end

    always_comb begin
        unique case (addr)
            A_LEVEL: rd_next = pin_level;
            A_LATCH: rd_next = out_latch;
            A_DIR:   rd_next = dir_mask;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end
endmodule

// File: rtl/gpio_irq_fsm.sv
module gpio_irq_fsm
    import gpio_regbank_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_level,
    input  logic [WIDTH-1:0] dir_mask,
    input  logic             level_read,
    output logic             irq_n
);
    irq_state_t       state_q, state_d;
    logic [WIDTH-1:0] snap_q;
    logic             changed;

    assign changed = |((pin_level ^ snap_q) & dir_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          snap_q <= '1;
        else if (level_read) snap_q <= pin_level;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (!level_read && changed) state_d = IRQ_PEND;
            IRQ_PEND: if (level_read)             state_d = IRQ_IDLE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IRQ_PEND: irq_n = 1'b0;
            default:  irq_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_regbank_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_out,
    output logic              irq_n
);
    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(ADDR_LEVEL);

    logic [WIDTH-1:0] pin_level;
    logic [WIDTH-1:0] out_latch;
    logic [WIDTH-1:0] dir_mask;
    logic             level_read;

    assign level_read = rd_en && (addr == A_LEVEL);

    gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_level)
    );

    gpio_port_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .pin_level (pin_level),
        .rd_data   (rd_data),
        .out_latch (out_latch),
        .dir_mask  (dir_mask)
    );

    gpio_irq_fsm #(.WIDTH(WIDTH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_level  (pin_level),
        .dir_mask   (dir_mask),
        .level_read (level_read),
        .irq_n      (irq_n)
    );

    for (genvar b = 0; b < WIDTH; b++) begin : g_pin
        assign pin_oe[b]  = ~dir_mask[b];
        assign pin_out[b] = out_latch[b];
    end
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [WIDTH-1:0]  wr_data,
    input logic [WIDTH-1:0]  rd_data,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  pin_out,
    input logic              irq_n
);
    localparam logic [ADDR_W-1:0] A0 = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A2 = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A3 = ADDR_W'(3);

    p_latch_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A1) |=> (pin_out == $past(wr_data)));

    p_latch_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A1) |=> (rd_data == $past(pin_out)));

    p_dir_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A3) |=> (pin_oe == ~$past(wr_data)));

    p_ignored_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A0 || addr == A2)) |=> ($stable(pin_out) && $stable(pin_oe)));

    p_hole_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A2) |=> (rd_data == '0));

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A0) |=> irq_n);

    p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> !$past(rd_en && addr == A0));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind gpio_regbank gpio_regbank_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_oe  (pin_oe),
    .pin_out (pin_out),
    .irq_n   (irq_n)
);

// File: tb/gpio_regbank_bench.sv
`timescale 1ns/1ps
module gpio_regbank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;
    logic       irq_n;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    gpio_regbank u_gpio_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .irq_n(irq_n)
    );

    // behavioural reference: pin history queue, registers as integers
    logic [7:0] pin_hist[$] = '{8'hFF, 8'hFF};
    logic [7:0] m_snap = 8'hFF, m_out = 8'hFF, m_dir = 8'hFF, m_rd = 8'h00;
    bit         m_pend = 0;

    always @(posedge clk) begin
        logic [7:0] lvl;
        bit         diff;
        lvl  = pin_hist[0];
        diff = ((lvl ^ m_snap) & m_dir) != 0;
        if (!rst_n) begin
            pin_hist = '{8'hFF, 8'hFF};
            m_snap = 8'hFF; m_out = 8'hFF; m_dir = 8'hFF; m_rd = 8'h00; m_pend = 0;
        end else begin
            if (rd_en) begin
                case (addr)
                    2'd0: m_rd = lvl;
                    2'd1: m_rd = m_out;
                    2'd3: m_rd = m_dir;
                    default: m_rd = 8'h00;
                endcase
            end
            if (rd_en && addr == 2'd0) begin
                m_snap = lvl;
                m_pend = 0;
            end else if (diff) begin
                m_pend = 1;
            end
            if (wr_en && addr == 2'd1) m_out = wr_data;
            if (wr_en && addr == 2'd3) m_dir = wr_data;
            void'(pin_hist.pop_front());
            pin_hist.push_back(pin_in);
        end
    end

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%02h expected=%02h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        check(tag, "rd_data", rd_data, m_rd);
        check("R7 R8", "irq_n", {7'd0, irq_n}, {7'd0, !m_pend});
        check("R4", "pin_oe", pin_oe, ~m_dir);
        check("R3", "pin_out", pin_out, m_out);
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    task automatic bus(bit w, bit r, logic [1:0] a, logic [7:0] d);
        wr_en = w; rd_en = r; addr = a; wr_data = d;
        tick();
        wr_en = 0; rd_en = 0;
    endtask

    initial begin
        tick(); tick();
        // R1 reset values
        check("R1", "rst rd_data", rd_data, 8'h00);
        check("R1", "rst pin_oe", pin_oe, 8'h00);
        check("R1", "rst pin_out", pin_out, 8'hFF);
        check("R1", "rst irq_n", {7'd0, irq_n}, 8'h01);
        rst_n = 1;
        tick();

        // R2 level read after synchronizer
        tag = "R2";
        pin_in = 8'hA5;
        tick(); tick(); tick();
        check("R7", "irq low", {7'd0, irq_n}, 8'h00);
        bus(0, 1, 2'd0, 8'h00);
        check("R2", "level read", rd_data, 8'hA5);
        check("R8", "irq cleared", {7'd0, irq_n}, 8'h01);

        // R3 latch readback differs from pins
        tag = "R3";
        bus(1, 0, 2'd1, 8'h3C);
        check("R3", "pin_out", pin_out, 8'h3C);
        bus(0, 1, 2'd1, 8'h00);
        check("R3", "latch read", rd_data, 8'h3C);

        // R4 direction: low nibble inputs, high nibble outputs
        tag = "R4";
        bus(1, 0, 2'd3, 8'h0F);
        check("R4", "pin_oe", pin_oe, 8'hF0);
        bus(0, 1, 2'd3, 8'h00);
        check("R4", "dir read", rd_data, 8'h0F);

        // R9 change on output pins only: no interrupt
        tag = "R9";
        pin_in = 8'h55;
        repeat (5) tick();
        check("R9", "no irq", {7'd0, irq_n}, 8'h01);
        bus(0, 1, 2'd0, 8'h00);
        check("R2", "level incl outputs", rd_data, 8'h55);

        // R7 input pin change raises interrupt on third edge
        tag = "R7";
        pin_in = 8'h54;
        tick(); tick();
        check("R7", "irq not yet", {7'd0, irq_n}, 8'h01);
        tick();
        check("R7", "irq asserted", {7'd0, irq_n}, 8'h00);
        tag = "R8";
        bus(0, 1, 2'd0, 8'h00);
        check("R8", "irq cleared", {7'd0, irq_n}, 8'h01);

        // R5 ignored writes
        tag = "R5";
        bus(1, 0, 2'd0, 8'h00);
        bus(1, 0, 2'd2, 8'h00);
        check("R5", "pin_out kept", pin_out, 8'h3C);
        check("R5", "pin_oe kept", pin_oe, 8'hF0);

        // R6 hole read
        tag = "R6";
        bus(0, 1, 2'd2, 8'h00);
        check("R6", "hole read", rd_data, 8'h00);

        // R10 hold and read-before-write
        tag = "R10";
        bus(1, 1, 2'd1, 8'hC3);
        check("R10", "old value", rd_data, 8'h3C);
        repeat (3) tick();
        check("R10", "held", rd_data, 8'h3C);

        // mixed traffic
        tag = "R10";
        for (int i = 0; i < 400; i++) begin
            wr_en = 1'($urandom);
            rd_en = 1'($urandom);
            addr = 2'($urandom);
            wr_data = 8'($urandom);
            if ($urandom % 4 == 0) pin_in = 8'($urandom);
            tick();
        end
        wr_en = 0; rd_en = 0;
        tick();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL timeout actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule